// File: doc/BRIEF.md
# Double-Buffered Multimode Serial Transmitter

This block sends bytes on a single serial line. The host writes a byte into a one-word holding register. When the shift register has no bits left to present, the held byte moves into it and the empty flag rises again. The host can therefore queue the next byte while the current frame is still going out. An interrupt request follows the empty flag, gated by an enable input. The request marks the moment the holding register frees up, not the end of a frame.

Three framings are offered. The plain asynchronous framing wraps the byte in a low start bit and a high stop bit. The address-marking asynchronous framing adds one extra bit, taken from an input, between the last data bit and the stop bit. The synchronous framing sends only the data bits, and consecutive bytes follow each other with no gap. A one-cycle bit tick from outside sets the bit period. The serial output moves only on that tick.

Top module: `ser_tx_dbuf`

## Requirements
- R1: After reset the empty flag `tx_empty` is 1 and the serial line `txd` is 1.
- R2: A write (`wr_en` high) clears `tx_empty` at that clock edge. If the shifter holds no pending bits, the byte moves into it on the next edge, and `tx_empty` returns to 1 there.
- R3: `irq` is high exactly when `tx_empty` is 1 and `irq_en` is 1.
- R4: Mode code 0, and code 3 as well, sends a low start bit, then data bits 0 through 7 with bit 0 first, then a high stop bit (10 bits).
- R5: Mode code 1 sends a low start bit, data bits 0 through 7 with bit 0 first, the value of `ad_bit`, then a high stop bit (11 bits).
- R6: Mode code 2 sends only data bits 0 through 7, bit 0 first. A byte already queued starts on the tick right after the last bit of the previous byte.
- R7: `txd` changes only on the clock edge where `bit_tick` is high, and each bit lasts one tick period. One tick after the last bit of a frame, with nothing queued, the line returns high.
- R8: A queued byte waits while the shifter still has bits to present, and `tx_empty` stays 0 during that time. The byte transfers once the last bit of the current frame has gone onto the line.
- R9: A write while `tx_empty` is 0 replaces the queued byte, and the earlier queued byte is never sent.
- R10: `mode` and `ad_bit` are captured when the byte transfers into the shifter. Changing them later does not alter the frame in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | One-cycle write strobe for the holding register |
| wr_data | input | DATA_W | Byte to queue |
| mode | input | 2 | Framing select: 0/3 plain async, 1 address-marking async, 2 synchronous |
| ad_bit | input | 1 | Value of the extra bit in mode 1 |
| bit_tick | input | 1 | One-cycle bit-period enable |
| irq_en | input | 1 | Interrupt enable |
| txd | output | 1 | Serial data line |
| tx_empty | output | 1 | Holding register free |
| irq | output | 1 | Interrupt request level |

## Verification
The hardest case to reach from the ports is a byte waiting in the holding register while the shifter is still busy. The bench has to show that the flag stays low during that wait, that the transfer happens right after the final bit, and that no gap or doubled bit appears at the frame boundary. To get there, the bench writes a first byte, lets it transfer, and writes a second byte before issuing any tick. It then steps the tick by hand, checking the flag in the middle of the frame and again after the final bit. The same setup, with one more write placed before the transfer, checks the overwrite case.

// File: rtl/ser_tx_pkg.sv
package ser_tx_pkg;

  typedef enum logic [1:0] {
    FMT_ASYNC     = 2'd0,
    FMT_ADDR      = 2'd1,
    FMT_SYNC      = 2'd2,
    FMT_ASYNC_ALT = 2'd3
  } fmt_e;

  // Number of line bits a frame of dw data bits occupies in format f.
  function automatic int frame_len(fmt_e f, int dw);
    case (f)
      FMT_ADDR: return dw + 3;
      FMT_SYNC: return dw;
      default:  return dw + 2;
    endcase
  endfunction

endpackage

// File: rtl/tx_holdreg.sv
module tx_holdreg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              shift_free,
  output logic [DATA_W-1:0] hold_data,
  output logic              empty,
  output logic              xfer
);

  // Transfer whenever a byte is pending and the shifter has no bits left.
  assign xfer = !empty && shift_free;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      empty     <= 1'b1;
      hold_data <= '0;
    end else begin
      if (wr_en) begin
        hold_data <= wr_data;
        empty     <= 1'b0;
      end else if (xfer) begin
        empty     <= 1'b1;
      end
    end
  end

  AST_WR_CLEARS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !empty); // R2
  AST_XFER_SETS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && !wr_en) |=> empty); // R2

endmodule

// File: rtl/tx_shifter.sv
module tx_shifter
  import ser_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  fmt_e              fmt,
  input  logic              ad_bit,
  output logic              txd,
  output logic              free,
  output logic              busy
);

  localparam int FMAX  = DATA_W + 3;
  localparam int CNT_W = $clog2(FMAX + 1);

  logic [FMAX-1:0]  sr;
  logic [CNT_W-1:0] left;
  logic [FMAX-1:0]  frame;
  logic [CNT_W-1:0] flen;

  // Frame image, bit 0 goes on the line first.
  always_comb begin
    case (fmt)
      FMT_ADDR: frame = {1'b1, ad_bit, load_data, 1'b0};
      FMT_SYNC: frame = {3'b111, load_data};
      default:  frame = {2'b11, load_data, 1'b0};
    endcase
    flen = CNT_W'(frame_len(fmt, DATA_W));
  end

  assign free = (left == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr   <= '1;
      left <= '0;
      txd  <= 1'b1;
      busy <= 1'b0;
    end else if (load) begin
      if (tick) begin
        txd  <= frame[0];
        sr   <= {1'b1, frame[FMAX-1:1]};
        left <= flen - CNT_W'(1);
        busy <= 1'b1;
      end else begin
        sr   <= frame;
        left <= flen;
      end
    end else if (tick) begin
      if (left != '0) begin
        txd  <= sr[0];
        sr   <= {1'b1, sr[FMAX-1:1]};
        left <= left - CNT_W'(1);
        busy <= 1'b1;
      end else if (busy) begin
        txd  <= 1'b1;
        busy <= 1'b0;
      end
    end
  end

  AST_TXD_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(txd)); // R7
  AST_LOAD_ONLY_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (left == '0)); // R8
  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd); // R7

endmodule

// File: rtl/ser_tx_dbuf.sv
module ser_tx_dbuf
  import ser_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        mode,
  input  logic              ad_bit,
  input  logic              bit_tick,
  input  logic              irq_en,
  output logic              txd,
  output logic              tx_empty,
  output logic              irq
);

  logic [DATA_W-1:0] hold_data;
  logic              xfer;
  logic              shift_free;
  logic              shift_busy;
  fmt_e              fmt;

  assign fmt = fmt_e'(mode);

  tx_holdreg #(.DATA_W(DATA_W)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .shift_free(shift_free),
    .hold_data (hold_data),
    .empty     (tx_empty),
    .xfer      (xfer)
  );

  tx_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (bit_tick),
    .load     (xfer),
    .load_data(hold_data),
    .fmt      (fmt),
    .ad_bit   (ad_bit),
    .txd      (txd),
    .free     (shift_free),
    .busy     (shift_busy)
  );

  assign irq = tx_empty & irq_en;

endmodule

// File: tb/sim_ser_tx_dbuf.sv
module sim_ser_tx_dbuf;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [1:0] mode = '0;
  logic       ad_bit = 1'b0;
  logic       bit_tick = 1'b0;
  logic       irq_en = 1'b0;
  logic       txd, tx_empty, irq;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ser_tx_dbuf #(.DATA_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .mode(mode),
    .ad_bit(ad_bit), .bit_tick(bit_tick), .irq_en(irq_en),
    .txd(txd), .tx_empty(tx_empty), .irq(irq)
  );

  // {mode, ad, data}
  localparam logic [10:0] VEC [6] = '{
    {2'd0, 1'b0, 8'hA5}, {2'd1, 1'b1, 8'h3C}, {2'd1, 1'b0, 8'hFF},
    {2'd2, 1'b0, 8'h81}, {2'd3, 1'b0, 8'h5A}, {2'd0, 1'b1, 8'h00}
  };

  function automatic int exp_len(logic [1:0] m);
    if (m == 2'd2) return 8;
    if (m == 2'd1) return 11;
    return 10;
  endfunction

  // Expected line bits, index = order on the line.
  function automatic logic [15:0] exp_bits(logic [1:0] m, logic a, logic [7:0] d);
    logic [15:0] v = '1;
    int p = 0;
    if (m != 2'd2) begin v[p] = 1'b0; p++; end
    for (int i = 0; i < 8; i++) begin v[p] = d[i]; p++; end
    if (m == 2'd1) begin v[p] = a; p++; end
    if (m != 2'd2) begin v[p] = 1'b1; p++; end
    return v;
  endfunction

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic write_byte(input logic [7:0] d);
    wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic tick_once(output logic b);
    bit_tick = 1'b1;
    @(negedge clk);
    bit_tick = 1'b0;
    b = txd;
    repeat (3) @(negedge clk);
    if (txd !== b) begin
      checks++; errors++;
      $display("FAIL R7 txd moved without tick got %b expected %b", txd, b);
    end
  endtask

  task automatic collect(input int n, output logic [15:0] got);
    logic b;
    got = '1;
    for (int i = 0; i < n; i++) begin
      tick_once(b);
      got[i] = b;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog got timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] got, e;
    logic b;
    int n;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 empty", 16'(tx_empty), 16'd1);
    check("R1 txd", 16'(txd), 16'd1);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 interrupt gating
    irq_en = 1'b0; #1;
    check("R3 irq disabled", 16'(irq), 16'd0);
    irq_en = 1'b1; #1;
    check("R3 irq enabled", 16'(irq), 16'd1);

    // Vector table: R4 R5 R6 framings, R2 flag timing, R7 tick timing
    for (int k = 0; k < 6; k++) begin
      mode = VEC[k][10:9]; ad_bit = VEC[k][8];
      write_byte(VEC[k][7:0]);
      check("R2 cleared by write", 16'(tx_empty), 16'd0);
      check("R3 irq low while full", 16'(irq), 16'd0);
      @(negedge clk);
      check("R2 set on transfer", 16'(tx_empty), 16'd1);
      check("R7 no change before tick", 16'(txd), 16'd1);
      n = exp_len(mode);
      collect(n, got);
      e = exp_bits(mode, ad_bit, VEC[k][7:0]);
      case (mode)
        2'd1: check("R5 frame", got, e);
        2'd2: check("R6 frame", got, e);
        default: check("R4 frame", got, e);
      endcase
      tick_once(b);
      check("R7 idle high", 16'(b), 16'd1);
    end

    // R6 R8 back-to-back synchronous bytes
    mode = 2'd2;
    write_byte(8'hC3);
    @(negedge clk);
    write_byte(8'h6E);
    collect(4, got);
    check("R8 held while busy", 16'(tx_empty), 16'd0);
    begin
      logic [15:0] g2;
      collect(4, g2);
      got[7:4] = g2[3:0];
    end
    check("R8 transfer after last bit", 16'(tx_empty), 16'd1);
    check("R6 first sync byte", {8'h00, got[7:0]}, 16'h00C3);
    collect(8, got);
    check("R6 second sync byte no gap", {8'h00, got[7:0]}, 16'h006E);
    tick_once(b);
    check("R7 idle after sync", 16'(b), 16'd1);

    // R9 overwrite of queued byte
    mode = 2'd0;
    write_byte(8'h11);
    @(negedge clk);
    write_byte(8'h22);
    write_byte(8'h99);
    collect(10, got);
    check("R9 first frame", got, exp_bits(2'd0, 1'b0, 8'h11));
    collect(10, got);
    check("R9 replaced byte sent", got, exp_bits(2'd0, 1'b0, 8'h99));
    tick_once(b);

    // R10 mode and ad captured at transfer
    mode = 2'd1; ad_bit = 1'b1;
    write_byte(8'h4B);
    @(negedge clk);
    mode = 2'd2; ad_bit = 1'b0;
    collect(11, got);
    check("R10 frame kept", got, exp_bits(2'd1, 1'b1, 8'h4B));

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule